// File: doc/BRIEF.md
# Receiver Event Flag Register with Guarded Clear

This block holds the event flags and status view for a CAN-style receiver, together with a per-flag interrupt-enable register and one combined interrupt line. Four event flags are latched from hardware. A wake-up pulse, an overrun pulse and a buffer-full level each set their own flag. A fourth flag is set whenever the receiver or transmitter state code changes. Two 2-bit state codes, one for the receiver and one for the transmitter, are sampled from inputs and shown in the middle of the flag register as read-only fields.

Software reads both registers over a small synchronous bus. The bus has an address, a write strobe, write data and a combinational read-data return. A flag is cleared by writing 1 to its bit. That clear is refused while the condition behind the flag is still present, so a flag cannot be lost while its cause persists. The interrupt line is high whenever any flag is set together with its own enable bit.

Top module: `rxflag_regbank`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_o` is 0.
- R2: A cycle with `wake_pulse_i` high sets flag bit 7. A cycle with `overrun_pulse_i` high sets flag bit 1. Any cycle with `rx_full_i` high sets flag bit 0. Each flag is readable after the next rising clock edge.
- R3: Flag bit 6 is set at a clock edge when `rx_state_i` or `tx_state_i` differs from the value sampled at the previous edge. The sampled values are 0 after reset.
- R4: At the flag address, bits 5:4 read the receiver state and bits 3:2 read the transmitter state, as sampled at the last clock edge. Writes to bits 5:2 do not change them.
- R5: Writing 1 to a flag bit (7, 6, 1 or 0) at the flag address clears that flag at the next edge, provided its source is inactive in that cycle. Writing 0 to a flag bit leaves it unchanged.
- R6: A clear is refused if the flag's source is active in the same cycle: the wake pulse for bit 7, a state change for bit 6, the overrun pulse for bit 1, or `rx_full_i` high for bit 0. In that case the flag stays 1.
- R7: At the enable address, bits 7, 6, 1 and 0 are plain read/write enable bits. Bits 5:2 read 0 and ignore writes.
- R8: `irq_o` is 1 exactly when some flag bit and the enable bit at the same position are both 1.
- R9: Reads from any address other than the flag address (default 4) and the enable address (default 5) return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address for reads and writes |
| wr_en_i | input | 1 | Write strobe, sampled at the clock edge |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data for `addr_i` |
| wake_pulse_i | input | 1 | Wake-up event pulse |
| overrun_pulse_i | input | 1 | Receive overrun event pulse |
| rx_full_i | input | 1 | Receive buffer full level |
| rx_state_i | input | ST_W | Receiver state code |
| tx_state_i | input | ST_W | Transmitter state code |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The functions that can collide are a hardware set and a software write-1 clear aimed at the same flag in the same cycle. The bench provokes this directly: it pulses the wake input while writing 0x80, and it holds the buffer-full level while writing 0x01. It also lets random pulses, level changes, state changes and writes overlap freely. Each outcome is judged against a bench model in which the set takes priority. The flag must read 1 after the edge, and a later clear issued with the source quiet must then succeed.

// File: rtl/rxflag_pkg.sv
package rxflag_pkg;

   localparam int REG_W    = 8;

   localparam int WAKE_BIT = 7;
   localparam int CHG_BIT  = 6;
   localparam int OVR_BIT  = 1;
   localparam int FULL_BIT = 0;

   localparam int RXST_LSB = 4;
   localparam int TXST_LSB = 2;
   localparam int FIELD_W  = 2;

   localparam logic [REG_W-1:0] FLAG_MASK = 8'b1100_0011;

   typedef logic [REG_W-1:0] reg_word_t;

endpackage

// File: rtl/rxflag_src_cond.sv
module rxflag_src_cond
   import rxflag_pkg::*;
#(
   parameter int ST_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wake_pulse_i,
   input  logic            overrun_pulse_i,
   input  logic            rx_full_i,
   input  logic [ST_W-1:0] rx_state_i,
   input  logic [ST_W-1:0] tx_state_i,
   output reg_word_t       src_vec_o,
   output logic [ST_W-1:0] rx_mirror_o,
   output logic [ST_W-1:0] tx_mirror_o
);

   logic [ST_W-1:0] rx_q;
   logic [ST_W-1:0] tx_q;
   logic            state_moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
         tx_q <= '0;
      end else begin
         rx_q <= rx_state_i;
         tx_q <= tx_state_i;
      end
   end

   assign state_moved = (rx_state_i != rx_q) || (tx_state_i != tx_q);

   always_comb begin
      src_vec_o           = '0;
      src_vec_o[WAKE_BIT] = wake_pulse_i;
      src_vec_o[CHG_BIT]  = state_moved;
      src_vec_o[OVR_BIT]  = overrun_pulse_i;
      src_vec_o[FULL_BIT] = rx_full_i;
   end

   assign rx_mirror_o = rx_q;
   assign tx_mirror_o = tx_q;

endmodule

// File: rtl/rxflag_w1c_bit.sv
module rxflag_w1c_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_i)
         flag_q <= 1'b1;
      else if (clr_i)
         flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/rxflag_ien_reg.sv
module rxflag_ien_reg
   import rxflag_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_hit_i,
   input  reg_word_t wr_data_i,
   output reg_word_t ien_o
);

   reg_word_t ien_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ien_q <= '0;
      else if (wr_hit_i)
         ien_q <= wr_data_i & FLAG_MASK;
   end

   assign ien_o = ien_q;

endmodule

// File: rtl/rxflag_regbank.sv
module rxflag_regbank
   import rxflag_pkg::*;
#(
   parameter int          ADDR_W    = 4,
   parameter int unsigned FLAG_ADDR = 4,
   parameter int unsigned IEN_ADDR  = 5,
   parameter int          ST_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic [7:0]        wr_data_i,
   output logic [7:0]        rd_data_o,
   input  logic              wake_pulse_i,
   input  logic              overrun_pulse_i,
   input  logic              rx_full_i,
   input  logic [ST_W-1:0]   rx_state_i,
   input  logic [ST_W-1:0]   tx_state_i,
   output logic              irq_o
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] FLAG_A = FLAG_ADDR[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] IEN_A  = IEN_ADDR[ADDR_W-1:0];

   if (ST_W != FIELD_W) begin : g_bad_st_w
      $error("ST_W must equal the 2-bit status field width");
   end
   if (FLAG_ADDR >= ADDR_SPAN || IEN_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("register address outside the address space");
   end
   if (FLAG_ADDR == IEN_ADDR) begin : g_addr_clash
      $error("flag and enable registers need distinct addresses");
   end

   logic            flag_wr_hit;
   logic            ien_wr_hit;
   reg_word_t       src_vec;
   reg_word_t       clr_vec;
   reg_word_t       flag_q;
   reg_word_t       ien_q;
   logic [ST_W-1:0] mirror_rx;
   logic [ST_W-1:0] mirror_tx;

   assign flag_wr_hit = wr_en_i && (addr_i == FLAG_A);
   assign ien_wr_hit  = wr_en_i && (addr_i == IEN_A);
   assign clr_vec     = flag_wr_hit ? wr_data_i : '0;

   rxflag_src_cond #(.ST_W(ST_W)) u_src (
      .clk             (clk),
      .rst_n           (rst_n),
      .wake_pulse_i    (wake_pulse_i),
      .overrun_pulse_i (overrun_pulse_i),
      .rx_full_i       (rx_full_i),
      .rx_state_i      (rx_state_i),
      .tx_state_i      (tx_state_i),
      .src_vec_o       (src_vec),
      .rx_mirror_o     (mirror_rx),
      .tx_mirror_o     (mirror_tx)
   );

   for (genvar gi = 0; gi < REG_W; gi++) begin : g_bit
      if (FLAG_MASK[gi]) begin : g_flag
         rxflag_w1c_bit u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (src_vec[gi]),
            .clr_i  (clr_vec[gi]),
            .flag_o (flag_q[gi])
         );
      end else begin : g_field
         assign flag_q[gi] = 1'b0;
      end
   end

   rxflag_ien_reg u_ien (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit_i  (ien_wr_hit),
      .wr_data_i (wr_data_i),
      .ien_o     (ien_q)
   );

   always_comb begin
      rd_data_o = '0;
      if (addr_i == FLAG_A) begin
         rd_data_o                      = flag_q;
         rd_data_o[RXST_LSB +: FIELD_W] = mirror_rx;
         rd_data_o[TXST_LSB +: FIELD_W] = mirror_tx;
      end else if (addr_i == IEN_A) begin
         rd_data_o = ien_q;
      end
   end

   assign irq_o = |(flag_q & ien_q);

endmodule

// File: rtl/rxflag_regbank_chk.sv
module rxflag_regbank_chk #(
   parameter int ST_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            flag_wr,
   input logic [7:0]      wr_data,
   input logic            wake,
   input logic            ovr,
   input logic            full,
   input logic [ST_W-1:0] rx_st,
   input logic [ST_W-1:0] tx_st,
   input logic [7:0]      flags,
   input logic [7:0]      ens,
   input logic [ST_W-1:0] mir_rx,
   input logic [ST_W-1:0] mir_tx,
   input logic            irq
);

   p_wake_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> flags[7]);

   p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> flags[1]);

   p_full_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> flags[0]);

   p_change_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((rx_st != mir_rx) || (tx_st != mir_tx)) |=> flags[6]);

   p_mirror_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((mir_rx == $past(rx_st)) && (mir_tx == $past(tx_st))));

   p_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[7] && !(flag_wr && wr_data[7])) |=> flags[7]);

   p_clear_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wr_data[0] && full) |=> flags[0]);

   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($countones(flags & ens) > 0));

   p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[7] && ens[7]) |-> irq);

endmodule

bind rxflag_regbank rxflag_regbank_chk #(.ST_W(ST_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .flag_wr (flag_wr_hit),
   .wr_data (wr_data_i),
   .wake    (wake_pulse_i),
   .ovr     (overrun_pulse_i),
   .full    (rx_full_i),
   .rx_st   (rx_state_i),
   .tx_st   (tx_state_i),
   .flags   (flag_q),
   .ens     (ien_q),
   .mir_rx  (mirror_rx),
   .mir_tx  (mirror_tx),
   .irq     (irq_o)
);

// File: tb/rxflag_regbank_tb_top.sv
module rxflag_regbank_tb_top;

   localparam int ADDR_W = 4;
   localparam logic [3:0] FLAG_A = 4'd4;
   localparam logic [3:0] IEN_A  = 4'd5;
   localparam logic [7:0] MASK   = 8'hC3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       wake = 1'b0;
   logic       ovr = 1'b0;
   logic       full = 1'b0;
   logic [1:0] rx_st = '0;
   logic [1:0] tx_st = '0;
   logic       irq;

   int errors = 0;
   int checks = 0;

   logic [7:0] exp_flags = '0;
   logic [7:0] exp_en = '0;
   logic [1:0] m_rx = '0;
   logic [1:0] m_tx = '0;

   always #10 clk = ~clk;

   rxflag_regbank #(.ADDR_W(ADDR_W)) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .addr_i          (addr),
      .wr_en_i         (wr_en),
      .wr_data_i       (wdata),
      .rd_data_o       (rdata),
      .wake_pulse_i    (wake),
      .overrun_pulse_i (ovr),
      .rx_full_i       (full),
      .rx_state_i      (rx_st),
      .tx_state_i      (tx_st),
      .irq_o           (irq)
   );

   function automatic logic [7:0] flag_view();
      logic [7:0] v;
      v = exp_flags & MASK;
      v[5:4] = m_rx;
      v[3:2] = m_tx;
      return v;
   endfunction

   task automatic chk8(input logic [7:0] act, input logic [7:0] expv, input string tag);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, expv);
      end
   endtask

   // reads both registers and irq without writing; stays within the low phase
   task automatic check_all(input string tag);
      wr_en = 1'b0;
      addr = FLAG_A;
      #1 chk8(rdata, flag_view(), {tag, " flag reg"});
      addr = IEN_A;
      #1 chk8(rdata, exp_en, {tag, " enable reg"});
      chk8({7'd0, irq}, {7'd0, |(exp_flags & exp_en)}, "R8 irq");
   endtask

   // applies current stimulus for one edge and advances the model
   task automatic cycle();
      logic [7:0] src;
      logic [7:0] clr;
      src = 8'h00;
      src[7] = wake;
      src[6] = (rx_st != m_rx) || (tx_st != m_tx);
      src[1] = ovr;
      src[0] = full;
      clr = (wr_en && addr == FLAG_A) ? (wdata & MASK) : 8'h00;
      @(posedge clk);
      exp_flags = ((exp_flags & ~(clr & ~src)) | src) & MASK;
      if (wr_en && addr == IEN_A) exp_en = wdata & MASK;
      m_rx = rx_st;
      m_tx = tx_st;
      @(negedge clk);
      wr_en = 1'b0;
      wake = 1'b0;
      ovr = 1'b0;
   endtask

   task automatic write(input logic [3:0] a, input logic [7:0] d);
      addr = a;
      wdata = d;
      wr_en = 1'b1;
   endtask

   task automatic read_at(input logic [3:0] a, input logic [7:0] expv, input string tag);
      wr_en = 1'b0;
      addr = a;
      #1 chk8(rdata, expv, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      read_at(FLAG_A, 8'h00, "R1 flag reset");
      read_at(IEN_A, 8'h00, "R1 enable reset");
      chk8({7'd0, irq}, 8'h00, "R1 irq reset");
      rst_n = 1'b1;
      @(negedge clk);

      wake = 1'b1; cycle();
      read_at(FLAG_A, 8'h80, "R2 wake set");
      write(FLAG_A, 8'h00); cycle();
      read_at(FLAG_A, 8'h80, "R5 zero write");
      wake = 1'b1; write(FLAG_A, 8'h80); cycle();
      read_at(FLAG_A, 8'h80, "R6 set beats clear");
      write(FLAG_A, 8'h80); cycle();
      read_at(FLAG_A, 8'h00, "R5 clear");

      full = 1'b1; cycle();
      read_at(FLAG_A, 8'h01, "R2 full set");
      write(FLAG_A, 8'h01); cycle();
      read_at(FLAG_A, 8'h01, "R6 full refused");
      full = 1'b0; write(FLAG_A, 8'h01); cycle();
      read_at(FLAG_A, 8'h00, "R5 full cleared");

      ovr = 1'b1; cycle();
      read_at(FLAG_A, 8'h02, "R2 overrun set");
      rx_st = 2'd2; tx_st = 2'd1; cycle();
      read_at(FLAG_A, 8'h66, "R3 R4 state change");
      write(FLAG_A, 8'hFF); cycle();
      read_at(FLAG_A, 8'h24, "R4 fields kept");

      write(IEN_A, 8'hFF); cycle();
      read_at(IEN_A, 8'hC3, "R7 enable mask");
      chk8({7'd0, irq}, 8'h00, "R8 no flag");
      wake = 1'b1; cycle();
      chk8({7'd0, irq}, 8'h01, "R8 irq raised");
      write(IEN_A, 8'h00); cycle();
      chk8({7'd0, irq}, 8'h00, "R8 irq masked");

      write(4'd0, 8'hFF); cycle();
      read_at(4'd0, 8'h00, "R9 unmapped read");
      read_at(FLAG_A, 8'hA4, "R9 flag untouched");
      read_at(IEN_A, 8'h00, "R9 enable untouched");
      check_all("R5/R6 directed end");

      for (int n = 0; n < 3000; n++) begin
         logic [2:0] pick;
         wake = ($urandom_range(9) == 0);
         ovr  = ($urandom_range(9) == 0);
         if ($urandom_range(7) == 0) full = ~full;
         if ($urandom_range(9) == 0) rx_st = 2'($urandom_range(3));
         if ($urandom_range(9) == 0) tx_st = 2'($urandom_range(3));
         pick = 3'($urandom_range(7));
         if (pick < 3'd3) begin
            case (pick)
               3'd0:    write(FLAG_A, 8'($urandom_range(255)));
               3'd1:    write(IEN_A, 8'($urandom_range(255)));
               default: write(4'($urandom_range(15)), 8'($urandom_range(255)));
            endcase
         end
         cycle();
         check_all("R2/R3/R5/R6 random");
      end

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule